// File: doc/BRIEF.md
# Power Gating Sequencer

This block drives the power switch enable and the isolation control of one switchable power domain. A one-cycle power-down request pulse starts a two-phase sequence: after a programmable delay, isolation is raised, and after a second programmable delay, the switch enable is dropped. A one-cycle power-up request pulse runs the mirror sequence: after one delay the switch enable is raised, and after another delay isolation is released. Every delay is counted in cycles of the block clock.

Software programs the block through a small 32-bit register port with a write strobe, a word index and combinational read data. There are four words. One holds a permission bit that decides whether a power-down request may remove power at all. Two hold the delay pairs for each direction. The last reports whether the most recent power-down request removed power, and whether a sequence is still running. The block has no data stream, so every pin is a plain level or pulse.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, sw_en is 1, iso is 0, and all four register words read 0.
- R2: The register words are selected by reg_addr: 0 for control, 1 for up timing, 2 for down timing, 3 for status. Control bit 0 is the power-down permission bit. Each timing word holds the first delay in bits 5:0 and the second delay in bits 13:8. All other bits read 0.
- R3: With permission set and the domain on, the edge that samples pd_req starts the down sequence. iso rises D1+1 cycles later, where D1 is down-timing bits 5:0. sw_en falls D2+1 cycles after that, where D2 is down-timing bits 13:8.
- R4: With the domain off, the edge that samples pu_req starts the up sequence. sw_en rises U1+1 cycles later, where U1 is up-timing bits 5:0. iso falls U2+1 cycles after that, where U2 is up-timing bits 13:8.
- R5: If permission is 0 when pd_req is sampled, sw_en and iso stay unchanged, no sequence starts (status bit 1 stays 0), and status bit 0 is cleared.
- R6: Status bit 0 becomes 1 on the same edge on which a down sequence drops sw_en.
- R7: Status bit 1 (busy) is 1 from the edge that starts a sequence until the edge that completes its last step, and 0 otherwise. sw_en and iso change only on edges where busy was 1.
- R8: pd_req and pu_req are ignored while a sequence is running. The timing of the running sequence does not change.
- R9: pu_req while the domain is on, and pd_req while it is off, have no effect.
- R10: A delay field of 0 makes its step happen on the next clock edge.
- R11: iso is 1 whenever sw_en is 0. Power is only removed while isolated, and isolation is only released while powered.
- R12: Writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the delay counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pd_req | input | 1 | Power-down request pulse |
| pu_req | input | 1 | Power-up request pulse |
| sw_en | output | 1 | Power switch enable, 1 = domain powered |
| iso | output | 1 | Isolation control, 1 = outputs clamped |

## Verification
Counting from the edge that samples a request, the first output step is due D+1 edges later and the second step a further D'+1 edges later. Busy rises on the sampling edge and falls with the last step. The status done bit settles on the same edge as the last down step. A refused request settles its status on the sampling edge itself. The bench drives inputs and samples outputs on falling edges. After each request pulse, it counts exactly D falling edges and checks that the output has not yet moved, then checks on the next falling edge that it has. This places each check on the first and last cycles of every delay window.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_ON     = 3'd0,
    ST_DN_ISO = 3'd1,
    ST_DN_SW  = 3'd2,
    ST_OFF    = 3'd3,
    ST_UP_SW  = 3'd4,
    ST_UP_ISO = 3'd5
  } seq_state_t;

  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_UP   = 1;
  localparam int unsigned WORD_DN   = 2;
  localparam int unsigned WORD_STAT = 3;
  localparam int unsigned SECOND_LSB = 8;
endpackage

// File: rtl/pgs_delay.sv
module pgs_delay #(
  parameter int unsigned DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          expired
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgs_regs.sv
module pgs_regs
  import pgs_pkg::*;
#(
  parameter int unsigned DW     = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              pd_done,
  output logic              permit,
  output logic [DW-1:0]     up_first,
  output logic [DW-1:0]     up_second,
  output logic [DW-1:0]     dn_first,
  output logic [DW-1:0]     dn_second
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      permit    <= 1'b0;
      up_first  <= '0;
      up_second <= '0;
      dn_first  <= '0;
      dn_second <= '0;
    end else if (we) begin
      case (addr)
        2'(WORD_CTRL): permit <= wdata[0];
        2'(WORD_UP): begin
          up_first  <= wdata[DW-1:0];
          up_second <= wdata[SECOND_LSB +: DW];
        end
        2'(WORD_DN): begin
          dn_first  <= wdata[DW-1:0];
          dn_second <= wdata[SECOND_LSB +: DW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'(WORD_CTRL): rdata[0] = permit;
      2'(WORD_UP): begin
        rdata[DW-1:0]          = up_first;
        rdata[SECOND_LSB +: DW] = up_second;
      end
      2'(WORD_DN): begin
        rdata[DW-1:0]          = dn_first;
        rdata[SECOND_LSB +: DW] = dn_second;
      end
      default: rdata[1:0] = {busy, pd_done};
    endcase
  end
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
  import pgs_pkg::*;
#(
  parameter int unsigned DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic          pu_req,
  input  logic          permit,
  input  logic [DW-1:0] up_first,
  input  logic [DW-1:0] up_second,
  input  logic [DW-1:0] dn_first,
  input  logic [DW-1:0] dn_second,
  output logic          sw_en,
  output logic          iso,
  output logic          busy,
  output logic          pd_done
);
  seq_state_t    state_q, state_d;
  logic          load;
  logic [DW-1:0] load_val;
  logic          expired;
  logic          set_iso, clr_iso, set_sw, clr_sw, mark_done, clear_done;

  pgs_delay #(.DW(DW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    load_val   = '0;
    set_iso    = 1'b0;
    clr_iso    = 1'b0;
    set_sw     = 1'b0;
    clr_sw     = 1'b0;
    mark_done  = 1'b0;
    clear_done = 1'b0;
    case (state_q)
      ST_ON: if (pd_req) begin
        if (permit) begin
          state_d  = ST_DN_ISO;
          load     = 1'b1;
          load_val = dn_first;
        end else begin
          clear_done = 1'b1;
        end
      end
      ST_DN_ISO: if (expired) begin
        state_d  = ST_DN_SW;
        set_iso  = 1'b1;
        load     = 1'b1;
        load_val = dn_second;
      end
      ST_DN_SW: if (expired) begin
        state_d   = ST_OFF;
        clr_sw    = 1'b1;
        mark_done = 1'b1;
      end
      ST_OFF: if (pu_req) begin
        state_d  = ST_UP_SW;
        load     = 1'b1;
        load_val = up_first;
      end
      ST_UP_SW: if (expired) begin
        state_d  = ST_UP_ISO;
        set_sw   = 1'b1;
        load     = 1'b1;
        load_val = up_second;
      end
      ST_UP_ISO: if (expired) begin
        state_d = ST_ON;
        clr_iso = 1'b1;
      end
      default: state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      sw_en   <= 1'b1;
      iso     <= 1'b0;
      pd_done <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_sw)          sw_en   <= 1'b1;
      else if (clr_sw)     sw_en   <= 1'b0;
      if (set_iso)         iso     <= 1'b1;
      else if (clr_iso)    iso     <= 1'b0;
      if (mark_done)       pd_done <= 1'b1;
      else if (clear_done) pd_done <= 1'b0;
    end
  end

  assign busy = (state_q != ST_ON) && (state_q != ST_OFF);
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int unsigned DW     = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pd_req,
  input  logic              pu_req,
  output logic              sw_en,
  output logic              iso
);
  logic          permit_w, busy_w, pd_done_w;
  logic [DW-1:0] up_first_w, up_second_w, dn_first_w, dn_second_w;

  pgs_regs #(.DW(DW), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy_w),
    .pd_done   (pd_done_w),
    .permit    (permit_w),
    .up_first  (up_first_w),
    .up_second (up_second_w),
    .dn_first  (dn_first_w),
    .dn_second (dn_second_w)
  );

  pgs_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .pu_req    (pu_req),
    .permit    (permit_w),
    .up_first  (up_first_w),
    .up_second (up_second_w),
    .dn_first  (dn_first_w),
    .dn_second (dn_second_w),
    .sw_en     (sw_en),
    .iso       (iso),
    .busy      (busy_w),
    .pd_done   (pd_done_w)
  );
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
  input logic clk,
  input logic rst_n,
  input logic pd_req,
  input logic sw_en,
  input logic iso,
  input logic busy,
  input logic permit,
  input logic pd_done
);
  // R11: never unpowered without isolation
  a_r11_iso_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> iso);

  // R3: power is removed only after isolation was already up
  a_r3_iso_before_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> $past(iso));

  // R4: isolation is released only after power was already back
  a_r4_power_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso) |-> $past(sw_en));

  // R6: completed power-down is recorded on the same edge
  a_r6_done_with_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> pd_done);

  // R7: outputs move only out of a running sequence
  a_r7_sw_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_en) |-> $past(busy));
  a_r7_iso_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(iso) |-> $past(busy));

  // R5: refused power-down changes nothing but the done flag
  a_r5_refused_request: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !permit && !busy && sw_en) |=> (!busy && sw_en && !iso && !pd_done));
endmodule

bind pwr_gate_seq pgs_checker u_pgs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .pd_req  (pd_req),
  .sw_en   (sw_en),
  .iso     (iso),
  .busy    (busy_w),
  .permit  (permit_w),
  .pd_done (pd_done_w)
);

// File: tb/test_pwr_gate_seq.sv
module test_pwr_gate_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pd_req = 1'b0;
  logic        pu_req = 1'b0;
  logic        sw_en, iso;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pwr_gate_seq i_pwr_gate_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pd_req(pd_req), .pu_req(pu_req), .sw_en(sw_en), .iso(iso)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // pulse a request: drive at a falling edge, returns at the falling edge after the sampling edge
  task automatic pulse_pd();
    pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
  endtask
  task automatic pulse_pu();
    pu_req = 1'b1; @(negedge clk); pu_req = 1'b0;
  endtask

  task automatic run_down(string req, int d1, int d2, bit poke);
    logic [31:0] v;
    wr(2'd2, 32'(d1) | (32'(d2) << 8));
    pulse_pd();
    rd(2'd3, v);
    chk("R7", "busy after down start", v[1], 1'b1);
    if (poke) begin
      pulse_pu(); pulse_pd();   // R8: ignored mid-sequence
      d1 = d1 - 2;
    end
    if (d1 > 0) begin
      wait_n(d1);
      chk(req, "iso before first step", iso, 1'b0);
    end
    wait_n(1);
    chk(req, "iso at first step", iso, 1'b1);
    if (d2 > 0) begin
      wait_n(d2);
      chk(req, "sw_en before second step", sw_en, 1'b1);
    end
    wait_n(1);
    chk(req, "sw_en at second step", sw_en, 1'b0);
    rd(2'd3, v);
    chk("R6", "status after power-down", v, 32'h1);
  endtask

  task automatic run_up(string req, int d1, int d2);
    logic [31:0] v;
    wr(2'd1, 32'(d1) | (32'(d2) << 8));
    pulse_pu();
    rd(2'd3, v);
    chk("R7", "busy after up start", v[1], 1'b1);
    if (d1 > 0) begin
      wait_n(d1);
      chk(req, "sw_en before first step", sw_en, 1'b0);
    end
    wait_n(1);
    chk(req, "sw_en at first step", sw_en, 1'b1);
    if (d2 > 0) begin
      wait_n(d2);
      chk(req, "iso before second step", iso, 1'b1);
    end
    wait_n(1);
    chk(req, "iso at second step", iso, 1'b0);
    rd(2'd3, v);
    chk("R7", "busy clear after up", v[1], 1'b0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "sw_en", sw_en, 1'b1);
    chk("R1", "iso", iso, 1'b0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", "register word", v, 32'h0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R2", "up timing mask", v, 32'h0000_3F3F);
    wr(2'd2, 32'h0000_2A15); rd(2'd2, v); chk("R2", "down timing fields", v, 32'h0000_2A15);
    wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, v); chk("R2", "control bit0 clear", v, 32'h0);
    wr(2'd0, 32'h0000_0001); rd(2'd0, v); chk("R2", "control bit0 set", v, 32'h1);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R12", "status write ignored", v, 32'h0);
    chk("R12", "outputs after status write", {sw_en, iso}, 2'b10);
  endtask

  task automatic t_redundant();
    logic [31:0] v;
    pulse_pd(); wait_n(3);
    chk("R9", "pd while off", {sw_en, iso}, 2'b01);
    rd(2'd3, v); chk("R9", "status after pd while off", v, 32'h1);
  endtask

  task automatic t_redundant_up();
    logic [31:0] v;
    pulse_pu(); wait_n(3);
    chk("R9", "pu while on", {sw_en, iso}, 2'b10);
    rd(2'd3, v); chk("R9", "status after pu while on", v[1], 1'b0);
  endtask

  task automatic t_refused();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    pulse_pd();
    chk("R5", "outputs after refused pd", {sw_en, iso}, 2'b10);
    rd(2'd3, v); chk("R5", "status after refused pd", v, 32'h0);
    wait_n(4);
    chk("R5", "outputs later", {sw_en, iso}, 2'b10);
    wr(2'd0, 32'h1);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_regs();
    run_down("R3", 3, 2, 1'b0);
    t_redundant();
    run_up("R4", 2, 4);
    t_redundant_up();
    t_refused();
    run_down("R10", 0, 0, 1'b0);
    run_up("R10", 0, 0);
    run_down("R8", 6, 1, 1'b1);
    run_up("R4", 5, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule